// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This block prepares the second source operand of an ALU instruction. It takes a register value, a two-bit shift kind, a five-bit immediate shift amount and the present carry flag, and returns the shifted operand together with the carry that the shift produces. It supports five shifts: logical left, logical right, arithmetic right and rotate right. The fifth is a 33-bit rotate through the carry, which is reached with the rotate-right code and an amount of zero. There is no arithmetic-left kind, because it would give the same result as logical left.

Zero amounts are treated in a special way. A left shift by zero passes the operand through unchanged. For the two right shifts, an amount of zero stands for a full-width shift. For the rotate, an amount of zero selects the rotate through the carry.

The parameter `REGISTER_OUT` adds a single output register stage. In that case the result and carry are captured only when `in_valid` is high. `out_valid` marks the cycle in which a new result is presented. When `REGISTER_OUT` is 0, the outputs follow the inputs combinationally.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 2'b00 with amount n from 1 to 31 gives the operand shifted left by n with zeros filled in. Carry-out is operand bit 32-n.
- R2: Kind code 2'b00 with amount 0 gives the operand unchanged. Carry-out equals `carry_in`.
- R3: Kind code 2'b01 with amount n from 1 to 31 gives the operand shifted right by n with zeros filled in. Carry-out is operand bit n-1.
- R4: Kind code 2'b01 with amount 0 is a shift by 32. The result is zero and carry-out is operand bit 31.
- R5: Kind code 2'b10 with amount n from 1 to 31 shifts right by n and fills with copies of bit 31. Carry-out is operand bit n-1.
- R6: Kind code 2'b10 with amount 0 gives 32 copies of operand bit 31. Carry-out is operand bit 31.
- R7: Kind code 2'b11 with amount n from 1 to 31 rotates right by n. Carry-out is operand bit n-1, which is also the new bit 31.
- R8: Kind code 2'b11 with amount 0 rotates right by one through the carry. Result bit 31 is `carry_in`, result bits 30..0 are operand bits 31..1, and carry-out is operand bit 0.
- R9: With the registered stage, reset clears `out_valid`, `result` and `carry_out` to 0. A value accepted with `in_valid` at one clock edge appears on the outputs after that edge, with `out_valid` high for exactly that cycle.
- R10: With the registered stage, a cycle with `in_valid` low leaves `result` and `carry_out` unchanged, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs carry an operation to shift |
| operand | input | WIDTH | Register value to shift |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| shift_amt | input | AMT_W | Immediate shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result presented this cycle |
| result | output | WIDTH | Shifted operand |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The hardest cases to reach are the boundary ones. These are a zero amount, whose meaning is different for each kind, and the extreme amounts 1 and 31, where the carry comes from bit 0 or bit 31. These cases only show up as wrong when the operand has different values at the bits involved. The bench therefore sweeps every kind, every amount and both carry-in values over operand patterns that include single set bits at each end, alternating bits and mixed-sign values. Expected results are computed with wide integer arithmetic. After each result, a cycle with `in_valid` low and a scrambled operand shows whether the held output changed.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int WIDTH = 32,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       shift_kind,
  input  logic [AMT_W-1:0] shift_amt,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  typedef enum logic [1:0] {K_LSL = 2'b00, K_LSR = 2'b01, K_ASR = 2'b10, K_ROR = 2'b11} kind_e;

  logic [WIDTH:0]   lsl_w, lsr_w, asr_w;
  logic [WIDTH-1:0] ror_w;
  logic [WIDTH-1:0] res_c;
  logic             cy_c;
  logic             amt_zero;

  assign amt_zero = (shift_amt == '0);
  assign lsl_w = {1'b0, operand} << shift_amt;
  assign lsr_w = {operand, 1'b0} >> shift_amt;
  assign asr_w = $unsigned($signed({operand, 1'b0}) >>> shift_amt);
  assign ror_w = (operand >> shift_amt) | (operand << (WIDTH - int'(shift_amt)));

  always_comb begin
    res_c = operand;
    cy_c  = carry_in;
    case (kind_e'(shift_kind))
      K_LSL: if (!amt_zero) begin
        res_c = lsl_w[WIDTH-1:0];
        cy_c  = lsl_w[WIDTH];
      end
      K_LSR: if (amt_zero) begin
        res_c = '0;
        cy_c  = operand[WIDTH-1];
      end else begin
        res_c = lsr_w[WIDTH:1];
        cy_c  = lsr_w[0];
      end
      K_ASR: if (amt_zero) begin
        res_c = {WIDTH{operand[WIDTH-1]}};
        cy_c  = operand[WIDTH-1];
      end else begin
        res_c = asr_w[WIDTH:1];
        cy_c  = asr_w[0];
      end
      default: if (amt_zero) begin
        res_c = {carry_in, operand[WIDTH-1:1]};
        cy_c  = operand[0];
      end else begin
        res_c = ror_w;
        cy_c  = ror_w[WIDTH-1];
      end
    endcase
  end

  generate
    if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
          carry_out <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result    <= res_c;
            carry_out <= cy_c;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_c;
      assign carry_out = cy_c;
    end
  endgenerate

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int WIDTH = 32,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] operand,
  input logic [1:0]       shift_kind,
  input logic [AMT_W-1:0] shift_amt,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);

  generate
    if (REGISTER_OUT) begin : g_reg_chk
      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R10
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry_out)));
      // R2
      lsl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 2'b00 && shift_amt == '0) |=>
          (result == $past(operand) && carry_out == $past(carry_in)));
      // R4
      lsr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 2'b01 && shift_amt == '0) |=>
          (result == '0 && carry_out == $past(operand[WIDTH-1])));
      // R6
      asr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 2'b10 && shift_amt == '0) |=>
          (result == {WIDTH{$past(operand[WIDTH-1])}} && carry_out == $past(operand[WIDTH-1])));
      // R8
      rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 2'b11 && shift_amt == '0) |=>
          (result[WIDTH-1] == $past(carry_in) && result[WIDTH-2:0] == $past(operand[WIDTH-1:1])
           && carry_out == $past(operand[0])));
    end else begin : g_comb_chk
      always_comb begin
        // R9
        comb_valid_chk: assert (out_valid == in_valid);
      end
    end
  endgenerate

endmodule

bind operand_shifter operand_shifter_chk #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) u_chk (.*);

// File: tb/tb_operand_shifter.sv
`timescale 1ns/1ps
module tb_operand_shifter;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, carry_in = 1'b0;
  logic [W-1:0] operand = '0;
  logic [1:0] shift_kind = 2'b00;
  logic [4:0] shift_amt = '0;
  logic out_valid, carry_out;
  logic [W-1:0] result;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  operand_shifter #(.WIDTH(W), .REGISTER_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out));

  function automatic string req_of(input logic [1:0] k, input int n);
    case (k)
      2'b00: return (n == 0) ? "R2" : "R1";
      2'b01: return (n == 0) ? "R4" : "R3";
      2'b10: return (n == 0) ? "R6" : "R5";
      default: return (n == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic model(input logic [W-1:0] op, input logic [1:0] k, input int n, input logic ci,
                       output logic [W-1:0] r, output logic c);
    longint unsigned u = {32'h0, op};
    longint s = longint'(signed'(op));
    int m = (n == 0 && (k == 2'b01 || k == 2'b10)) ? 32 : n;
    case (k)
      2'b00: begin
        r = (n == 0) ? op : W'(u << n);
        c = (n == 0) ? ci : 1'((u >> (32 - n)) & 1);
      end
      2'b01: begin r = W'(u >> m); c = 1'((u >> (m - 1)) & 1); end
      2'b10: begin r = W'(s >>> m); c = 1'((s >>> (m - 1)) & 1); end
      default: begin
        if (n == 0) begin r = W'((u >> 1) | ({63'h0, ci} << 31)); c = op[0]; end
        else begin r = W'((u >> n) | (u << (32 - n))); c = 1'((u >> (n - 1)) & 1); end
      end
    endcase
  endtask

  task automatic check(input string req, input bit ok, input string what,
                       input logic [W-1:0] ar, input logic ac, input logic [W-1:0] er, input logic ec);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual result=%h carry=%b expected result=%h carry=%b",
               req, what, ar, ac, er, ec);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [8];
    logic [W-1:0] er;
    logic ec;
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'hAAAA_AAAA;
    pats[3] = 32'h5555_5555; pats[4] = 32'hF00F_1234; pats[5] = 32'h7FFF_FFFE;
    pats[6] = 32'hFFFF_FFFF; pats[7] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", out_valid == 1'b0 && result == '0 && carry_out == 1'b0, "reset state",
          result, carry_out, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 32; n++) begin
        for (int p = 0; p < 8; p++) begin
          for (int ci = 0; ci < 2; ci++) begin
            operand = pats[p]; shift_kind = 2'(k); shift_amt = 5'(n); carry_in = 1'(ci);
            in_valid = 1'b1;
            model(pats[p], 2'(k), n, 1'(ci), er, ec);
            @(negedge clk);
            check(req_of(2'(k), n), result == er && carry_out == ec && out_valid,
                  $sformatf("kind=%0d amt=%0d op=%h ci=%0d", k, n, pats[p], ci),
                  result, carry_out, er, ec);
            // R10: idle cycle with scrambled inputs must hold the output
            in_valid = 1'b0;
            operand = ~pats[p] ^ 32'h1357_9BDF; shift_kind = 2'(k + 1); shift_amt = 5'(n + 7);
            carry_in = ~carry_in;
            @(negedge clk);
            check("R10", result == er && carry_out == ec && !out_valid,
                  $sformatf("hold after kind=%0d amt=%0d", k, n), result, carry_out, er, ec);
          end
        end
      end
    end
    // R9 back-to-back: two accepted values, each shown for one cycle
    in_valid = 1'b1; operand = 32'h0000_00F0; shift_kind = 2'b01; shift_amt = 5'd4; carry_in = 1'b0;
    @(negedge clk);
    check("R9", out_valid && result == 32'h0000_000F, "first of pair", result, carry_out, 32'h0000_000F, 1'b0);
    operand = 32'h0000_0003; shift_kind = 2'b00; shift_amt = 5'd31;
    @(negedge clk);
    check("R9", out_valid && result == 32'h8000_0000 && carry_out == 1'b1, "second of pair",
          result, carry_out, 32'h8000_0000, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", !out_valid, "valid drops", result, carry_out, 32'h8000_0000, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule